// File: doc/BRIEF.md
# Ones Gather Packer

This block takes a vector of W bits and returns a vector of the same width in which every set input bit has been moved down to the least significant end. The result is always a contiguous run of ones starting at bit 0, and the length of the run equals the number of ones in the input. Which input positions held the ones makes no difference to the result. Only the count matters.

The count is produced by a balanced binary tree of adders. The tree splits each range of input bits at its midpoint, so the adder depth grows with log2(W) and not with W. Each output bit then compares the count against its own index. An output register, selected by a parameter and on by default, puts one clock of latency on the result and gives it a synchronous, active-high clear. Typical uses are building fill masks, valid-lane masks and occupancy indicators from a scattered request vector.

Top module: `ones_gather`

## Requirements
- R1: The width W is a parameter, legal from 4 to 64 inclusive. The internal count is $clog2(W+1) bits wide, so it holds every value from 0 to W without wrapping.
- R2: Output bit i is 1 exactly when the number of ones in the input is strictly greater than i. The output equals the vector built by appending each set input bit, from bit 0 upward, at a running write position that starts at 0.
- R3: The output is always a thermometer code: ones fill bits 0 to k-1 and every bit above them is 0.
- R4: An all-zero input gives an all-zero output.
- R5: An all-ones input gives an all-ones output. For W=32 this is 32'hFFFF_FFFF.
- R6: With REG_OUT=1, the result for an input appears on out_vec one clock edge after that input is present, and out_vec does not change between edges.
- R7: With REG_OUT=1, while rst is high at a rising clock edge, out_vec becomes all zeros whatever the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high clear of the output register |
| in_vec | input | W | Scattered input bits |
| out_vec | output | W | Packed thermometer result |

## Verification
On every cycle the checker confirms that the output is a thermometer code, that the number of ones in it matches the number of ones in the previous cycle's input, that the adder tree's count matches the number of ones in the current input, and that the all-zero and all-ones inputs map to themselves. Other behaviour can be shown only by the bench's scenarios. These are the exact bit-for-bit agreement with a write-index reference loop over all 256 inputs at W=8 and a random sample at W=32, the one-edge latency with the output held steady between edges, and the clear under reset while the input is all ones.

// File: rtl/ones_gather_pkg.sv
package ones_gather_pkg;
    localparam int MIN_WIDTH = 4;
    localparam int MAX_WIDTH = 64;

    // Bits needed to hold a count in 0..w.
    function automatic int count_bits(input int w);
        return $clog2(w + 1);
    endfunction
endpackage

// File: rtl/ones_gather_sum.sv
// Balanced adder tree: splits the range at its midpoint and recurses.
module ones_gather_sum #(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  logic [N-1:0]  bits_i,
    output logic [CW-1:0] sum_o
);
    generate
        if (N == 1) begin : g_leaf
            assign sum_o = {{(CW-1){1'b0}}, bits_i};
        end else begin : g_node
            localparam int LO = N / 2;
            localparam int HI = N - LO;
            logic [CW-1:0] sum_lo;
            logic [CW-1:0] sum_hi;
            ones_gather_sum #(.N(LO), .CW(CW)) u_lo (
                .bits_i(bits_i[LO-1:0]),
                .sum_o (sum_lo)
            );
            ones_gather_sum #(.N(HI), .CW(CW)) u_hi (
                .bits_i(bits_i[N-1:LO]),
                .sum_o (sum_hi)
            );
            assign sum_o = sum_lo + sum_hi;
        end
    endgenerate
endmodule

// File: rtl/ones_gather_thermo.sv
// Count to thermometer: bit i is set when count exceeds i.
module ones_gather_thermo #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic [CW-1:0] cnt_i,
    output logic [W-1:0]  therm_o
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            localparam logic [CW-1:0] IDX = CW'(i);
            assign therm_o[i] = (cnt_i > IDX);
        end
    endgenerate
endmodule

// File: rtl/ones_gather.sv
module ones_gather #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_vec,
    output logic [W-1:0] out_vec
);
    localparam int CW = ones_gather_pkg::count_bits(W);

    // R1: legal width range
    generate
        if (W < ones_gather_pkg::MIN_WIDTH || W > ones_gather_pkg::MAX_WIDTH) begin : g_bad_width
            $error("ones_gather: W out of range");
        end
    endgenerate

    typedef struct packed {
        logic [W-1:0] res;
    } state_t;

    logic [CW-1:0] cnt;
    logic [W-1:0]  therm;
    state_t        st_d;
    state_t        st_q;

    ones_gather_sum #(.N(W), .CW(CW)) u_sum (
        .bits_i(in_vec),
        .sum_o (cnt)
    );

    ones_gather_thermo #(.W(W), .CW(CW)) u_thermo (
        .cnt_i  (cnt),
        .therm_o(therm)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = therm;
        if (rst) begin
            st_d.res = '0;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
            assign out_vec = st_q.res;
        end else begin : g_comb
            assign st_q    = '0;
            assign out_vec = therm;
        end
    endgenerate
endmodule

// File: rtl/ones_gather_chk.sv
module ones_gather_chk #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1,
    parameter int CW      = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  in_vec,
    input logic [W-1:0]  out_vec,
    input logic [CW-1:0] cnt
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] FULL = '1;

    // R3: thermometer shape
    a_r3_thermo_shape: assert property (@(posedge clk) disable iff (rst)
        ((out_vec & (out_vec + ONE)) == '0));

    // R1, R2: the tree's count equals the ones in the input
    a_r2_tree_count: assert property (@(posedge clk) disable iff (rst)
        (32'(cnt) == $countones(in_vec)));

    generate
        if (REG_OUT) begin : g_seq
            // R2, R6
            a_r2_ones_kept: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> ($countones(out_vec) == $past($countones(in_vec))));
            // R4
            a_r4_zero_in: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_vec) == '0) |-> (out_vec == '0));
            // R5
            a_r5_full_in: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(in_vec) == FULL) |-> (out_vec == FULL));
        end else begin : g_cmb
            a_r4_zero_in: assert property (@(posedge clk) disable iff (rst)
                (in_vec == '0) |-> (out_vec == '0));
            a_r5_full_in: assert property (@(posedge clk) disable iff (rst)
                (in_vec == FULL) |-> (out_vec == FULL));
        end
    endgenerate
endmodule

bind ones_gather ones_gather_chk #(.W(W), .REG_OUT(REG_OUT), .CW(CW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .in_vec (in_vec),
    .out_vec(out_vec),
    .cnt    (cnt)
);

// File: tb/sim_ones_gather.sv
`timescale 1ns/1ps
module sim_ones_gather;
    localparam int WA = 8;
    localparam int WB = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [WA-1:0] in_a = '0;
    logic [WB-1:0] in_b = '0;
    logic [WA-1:0] out_a;
    logic [WB-1:0] out_b;
    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    ones_gather #(.W(WA), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_vec(in_a), .out_vec(out_a));
    ones_gather #(.W(WB), .REG_OUT(1'b1)) u1 (
        .clk(clk), .rst(rst), .in_vec(in_b), .out_vec(out_b));

    // Reference: append each set bit at a running write position.
    function automatic logic [63:0] ref_pack(input logic [63:0] v, input int w);
        logic [63:0] r = '0;
        int wr = 0;
        for (int i = 0; i < w; i++) begin
            if (v[i]) begin
                r[wr] = 1'b1;
                wr++;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag(input logic [63:0] v, input int w);
        logic [63:0] full = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        if (v == '0) return "R4";
        if (v == full) return "R5";
        return "R2";
    endfunction

    logic [WA-1:0] exp_a;
    logic [WB-1:0] exp_b;
    logic [WA-1:0] prev_in_a;
    logic [WB-1:0] prev_in_b;

    // One cycle: apply at negedge, check at the following negedge.
    task automatic step(input logic [WA-1:0] va, input logic [WB-1:0] vb);
        in_a = va;
        in_b = vb;
        exp_a = WA'(ref_pack(64'(va), WA));
        exp_b = WB'(ref_pack(64'(vb), WB));
        prev_in_a = va;
        prev_in_b = vb;
        @(negedge clk);
        check(tag(64'(prev_in_a), WA), 64'(out_a), 64'(exp_a));
        check(tag(64'(prev_in_b), WB), 64'(out_b), 64'(exp_b));
    endtask

    initial begin
        in_a = 8'hA5;
        in_b = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        // R7: reset clears the register whatever the input
        check("R7", 64'(out_a), 64'd0);
        check("R7", 64'(out_b), 64'd0);
        rst = 1'b0;

        // R6: new input does not reach the output before the edge
        in_a = 8'h0F;
        in_b = 32'h0000_00FF;
        #2;
        check("R6", 64'(out_a), 64'd0);
        check("R6", 64'(out_b), 64'd0);
        @(negedge clk);
        check("R6", 64'(out_a), 64'h0F);
        check("R6", 64'(out_b), 64'hFF);

        // R2 R4 R5: exhaustive W=8, random W=32 alongside
        for (int v = 0; v < 256; v++) begin
            logic [WB-1:0] rb;
            if (v == 0) rb = '0;
            else if (v == 255) rb = '1;
            else if (v < 33) rb = WB'(64'd1 << (v - 1));
            else rb = $urandom;
            step(WA'(v), rb);
        end
        for (int k = 0; k < 300; k++) begin
            logic [WB-1:0] rb = $urandom & $urandom;
            step(WA'($urandom), rb);
        end
        // R5, R1: full count at the top of the range
        step('1, '1);
        check("R1", 64'(out_b), 64'hFFFF_FFFF);

        // R7: reset in mid-run with all-ones input
        in_a = '1;
        in_b = '1;
        rst = 1'b1;
        @(negedge clk);
        check("R7", 64'(out_a), 64'd0);
        check("R7", 64'(out_b), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R5", 64'(out_a), 64'hFF);
        check("R5", 64'(out_b), 64'hFFFF_FFFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule